// File: doc/BRIEF.md
# Timed-Sleep and Stop Controller

This block decides when a small processor core may sleep and when it must wake. A single STOP strobe from the instruction decoder leads to one of two sleep states. A mode bit selects which one. In the timed nap, the oscillator keeps running and only a free-running prescaler and an 8-bit compare timer stay active. In the deep halt, the oscillator enable is also dropped.

A nap ends on an external interrupt or on a timer compare match. The CPU clock returns on the next edge, with no settling wait. A one-cycle wake event is raised at the same time, together with a select that tells the core either to take the interrupt vector or to continue at the next instruction. A deep halt can only be left through reset. Every reset release holds the core's reset low for a fixed settling count of oscillator cycles, and software cannot change that count.

Top module: `wkup_sleep_ctrl`

## Requirements
- R1: After `rst_n` is released, `core_rst_n` stays 0 for exactly `STAB_CYC` rising clock edges (default 256000) and then stays 1. While `core_rst_n` is 0, `stop_req` is ignored.
- R2: When `stop_req` is sampled at 1 while running, with `wkup_mode` at 1 and `ext_irq` at 0, the block enters the nap. After that edge `cpu_clk_en` is 0 and `osc_en` stays 1.
- R3: When `stop_req` is sampled at 1 while running, with `wkup_mode` at 0, the block enters the halt. After that edge both `cpu_clk_en` and `osc_en` are 0, and the prescaler stops counting.
- R4: The prescaler counts every cycle except in the halt. During the nap with `tap_sel` = 3 (divide by 2^PRE_W, i.e. 2048), the timer advances on each edge at which the prescaler holds all ones. The timer starts from 0 at nap entry. The block wakes on the edge of the tick at which the timer equals `tmr_cmp`, which is tick number `tmr_cmp`+1.
- R5: During the nap, a `tap_sel` value other than 3 produces no timer ticks, so only `ext_irq` can wake the block.
- R6: During the nap, an `ext_irq` sampled at 1 wakes the block at that edge.
- R7: At every wake, `vec_sel` takes the value of `int_en` sampled on the wake edge (1 = take the vector, 0 = resume after STOP). It holds that value until the next wake.
- R8: In the halt, `ext_irq` and the timer have no effect. Only `rst_n` leaves the halt, and the R1 settling count follows.
- R9: If `stop_req` is sampled with `wkup_mode` at 1 and `ext_irq` at 1 in the same cycle, the block does not sleep. `cpu_clk_en` stays 1 and `wkup_evt` pulses.
- R10: While `rst_n` is 0, the outputs are `cpu_clk_en`=1, `osc_en`=1, `wkup_evt`=0, `vec_sel`=0 and `core_rst_n`=0.
- R11: On a wake from the nap, `wkup_evt` is 1 for one cycle. `cpu_clk_en` returns to 1 in that same cycle, with no added delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | External reset, active low, asynchronous |
| stop_req | input | 1 | STOP strobe from the decoder |
| wkup_mode | input | 1 | 1 selects the timed nap, 0 selects the deep halt |
| int_en | input | 1 | Global interrupt-enable flag |
| ext_irq | input | 1 | External interrupt request |
| tap_sel | input | 2 | Prescaler tap for the timer (3 = divide by 2048) |
| tmr_cmp | input | CNT_W | Timer compare value that sets the nap length |
| cpu_clk_en | output | 1 | CPU clock enable |
| osc_en | output | 1 | Oscillator enable |
| wkup_evt | output | 1 | One-cycle wake pulse |
| vec_sel | output | 1 | 1 = vector to the interrupt, 0 = resume |
| core_rst_n | output | 1 | Internal reset after settling, active low |

## Verification
Two pairs of functions can fall in the same cycle. A STOP strobe can coincide with an external interrupt. A timer match can also coincide with the prescaler tick that feeds it, and that tick is free-running, so its phase relative to nap entry varies. The bench provokes the first pair by raising `stop_req` and `ext_irq` on the same edge, and expects the clock enable never to drop while a wake pulse still appears. It judges the second pair by measuring the nap length against the window allowed by the tick phase, and by comparing every cycle against a behavioural model.

// File: rtl/wk_pkg.sv
package wk_pkg;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_NAP  = 2'd1,
    ST_HALT = 2'd2
  } wk_state_e;

  // Only this tap keeps ticking while napping
  localparam logic [1:0] NAP_TAP = 2'd3;

  // log2 of the divide ratio for a tap: four taps spaced by 4x, top tap = full prescaler
  function automatic int tap_log2(input int pre_w, input int sel);
    return pre_w - 2 * (3 - sel);
  endfunction

  // Next settling count; returns the terminal flag via the compare
  function automatic logic stab_done(input int unsigned cnt, input int unsigned cyc);
    return cnt == (cyc - 1);
  endfunction

endpackage

// File: rtl/wk_prescaler.sv
module wk_prescaler #(
  parameter int PRE_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic [1:0]       tap_sel,
  output logic [PRE_W-1:0] pre_q,
  output logic             tap_tick
);
  import wk_pkg::*;

  logic [3:0] tick_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pre_q <= '0;
    else if (run_en) pre_q <= pre_q + 1'b1;
  end

  for (genvar g = 0; g < 4; g++) begin : g_tap
    localparam int LG = tap_log2(PRE_W, g);
    assign tick_v[g] = &pre_q[LG-1:0];
  end

  assign tap_tick = run_en & tick_v[tap_sel];

  // R3
  pre_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> $stable(pre_q));

endmodule

// File: rtl/wk_timer0.sv
module wk_timer0 #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             tick,
  input  logic [CNT_W-1:0] cmp,
  output logic [CNT_W-1:0] cnt_q,
  output logic             match
);

  assign match = active & tick & (cnt_q == cmp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (!active) cnt_q <= '0;
    else if (tick)    cnt_q <= match ? '0 : cnt_q + 1'b1;
  end

  // R4
  tmr_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> (cnt_q == '0));

  // R5
  tmr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !tick) |=> $stable(cnt_q));

endmodule

// File: rtl/wk_stab.sv
module wk_stab #(
  parameter int STAB_CYC = 256000
) (
  input  logic clk,
  input  logic rst_n,
  output logic core_rst_n
);
  import wk_pkg::*;

  localparam int SW = $clog2(STAB_CYC + 1);

  logic [SW-1:0] cnt_q;
  logic          last_w;

  assign last_w = stab_done(32'(cnt_q), STAB_CYC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      core_rst_n <= 1'b0;
    end else if (!core_rst_n) begin
      if (last_w) core_rst_n <= 1'b1;
      else        cnt_q      <= cnt_q + 1'b1;
    end
  end

  // R1
  stab_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_rst_n) |-> ($past(cnt_q) == SW'(STAB_CYC - 1)));

  // R1
  stab_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst_n |=> core_rst_n);

endmodule

// File: rtl/wkup_sleep_ctrl.sv
module wkup_sleep_ctrl #(
  parameter int PRE_W    = 11,
  parameter int CNT_W    = 8,
  parameter int STAB_CYC = 256000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stop_req,
  input  logic             wkup_mode,
  input  logic             int_en,
  input  logic             ext_irq,
  input  logic [1:0]       tap_sel,
  input  logic [CNT_W-1:0] tmr_cmp,
  output logic             cpu_clk_en,
  output logic             osc_en,
  output logic             wkup_evt,
  output logic             vec_sel,
  output logic             core_rst_n
);
  import wk_pkg::*;

  wk_state_e        st_q, st_d;
  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] tcnt_q;
  logic             pre_tick;
  logic             nap_tick;
  logic             tmr_match;
  logic             go_stop;
  logic             instant_wake;
  logic             nap_wake;
  logic             wake_w;

  // Named internal events
  assign go_stop      = stop_req & core_rst_n & (st_q == ST_RUN);
  assign instant_wake = go_stop & wkup_mode & ext_irq;
  assign nap_wake     = (st_q == ST_NAP) & (ext_irq | tmr_match);
  assign wake_w       = instant_wake | nap_wake;
  assign nap_tick     = pre_tick & (tap_sel == NAP_TAP);

  assign osc_en     = (st_q != ST_HALT);
  assign cpu_clk_en = (st_q == ST_RUN);

  wk_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run_en(osc_en), .tap_sel(tap_sel),
    .pre_q(pre_q), .tap_tick(pre_tick)
  );

  wk_timer0 #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .active(st_q == ST_NAP), .tick(nap_tick),
    .cmp(tmr_cmp), .cnt_q(tcnt_q), .match(tmr_match)
  );

  wk_stab #(.STAB_CYC(STAB_CYC)) u_stab (
    .clk(clk), .rst_n(rst_n), .core_rst_n(core_rst_n)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_RUN:  if (go_stop && !instant_wake) st_d = wkup_mode ? ST_NAP : ST_HALT;
      ST_NAP:  if (nap_wake) st_d = ST_RUN;
      ST_HALT: st_d = ST_HALT;
      default: st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_RUN;
      wkup_evt <= 1'b0;
      vec_sel  <= 1'b0;
    end else begin
      st_q     <= st_d;
      wkup_evt <= wake_w;
      if (wake_w) vec_sel <= int_en;
    end
  end

  // R2
  nap_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go_stop && wkup_mode && !ext_irq) |=> (!cpu_clk_en && osc_en));

  // R3
  halt_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go_stop && !wkup_mode) |=> (!cpu_clk_en && !osc_en));

  // R8
  halt_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |=> (!osc_en && !cpu_clk_en && !wkup_evt));

  // R7
  vec_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wkup_evt |-> (vec_sel == $past(int_en)));

  // R11
  evt_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wkup_evt |-> cpu_clk_en);

  // R9
  same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    instant_wake |=> (cpu_clk_en && wkup_evt));

  // R1
  stop_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!core_rst_n && cpu_clk_en) |=> cpu_clk_en);

endmodule

// File: tb/wkup_sleep_ctrl_tb_top.sv
module wkup_sleep_ctrl_tb_top;
  localparam int PRE_W = 11;
  localparam int CNT_W = 8;
  localparam int STAB  = 40;
  localparam int DIV   = 1 << PRE_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stop_req = 1'b0, wkup_mode = 1'b0, int_en = 1'b0, ext_irq = 1'b0;
  logic [1:0] tap_sel = 2'd3;
  logic [CNT_W-1:0] tmr_cmp = '0;
  logic cpu_clk_en, osc_en, wkup_evt, vec_sel, core_rst_n;

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  wkup_sleep_ctrl #(.PRE_W(PRE_W), .CNT_W(CNT_W), .STAB_CYC(STAB)) dut_i (
    .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .wkup_mode(wkup_mode),
    .int_en(int_en), .ext_irq(ext_irq), .tap_sel(tap_sel), .tmr_cmp(tmr_cmp),
    .cpu_clk_en(cpu_clk_en), .osc_en(osc_en), .wkup_evt(wkup_evt),
    .vec_sel(vec_sel), .core_rst_n(core_rst_n)
  );

  // Behavioural reference: mode 0 awake, 1 napping, 2 halted
  int m_mode, m_pre, m_ticks, m_settle;
  bit m_evt, m_vec, m_ready, m_live = 0;

  always @(posedge clk) begin : model
    bit tk, nap_out, early, sleep_now;
    if (!rst_n) begin
      m_mode = 0; m_pre = 0; m_ticks = 0; m_settle = 0;
      m_evt = 0; m_vec = 0; m_ready = 0; m_live = 1;
    end else begin
      tk        = (m_mode == 1) && (tap_sel == 2'd3) && ((m_pre % DIV) == DIV - 1);
      nap_out   = (m_mode == 1) && (ext_irq || (tk && m_ticks == int'(tmr_cmp)));
      early     = (m_mode == 0) && m_ready && stop_req && wkup_mode && ext_irq;
      sleep_now = (m_mode == 0) && m_ready && stop_req && !early;
      m_evt = nap_out || early;
      if (m_evt) m_vec = int_en;
      if (m_mode == 1 && !nap_out) m_ticks = m_ticks + (tk ? 1 : 0);
      else m_ticks = 0;
      if (m_mode != 2) m_pre = (m_pre + 1) % DIV;
      if (!m_ready) begin
        if (m_settle + 1 >= STAB) m_ready = 1;
        else m_settle++;
      end
      if (nap_out) m_mode = 0;
      else if (sleep_now) m_mode = wkup_mode ? 1 : 2;
    end
  end

  task automatic fail_line(input string req, input string what, input int act, input int exp);
    n_fail++;
    $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
  endtask

  // Per-cycle comparison against the model
  always @(posedge clk) begin
    #1;
    if (m_live) begin
      n_run++;
      if (core_rst_n !== m_ready)       fail_line("R1", "core_rst_n", core_rst_n, m_ready);
      if (cpu_clk_en !== (m_mode == 0)) fail_line("R2", "cpu_clk_en", cpu_clk_en, m_mode == 0);
      if (osc_en !== (m_mode != 2))     fail_line("R3", "osc_en", osc_en, m_mode != 2);
      if (wkup_evt !== m_evt)           fail_line("R11", "wkup_evt", wkup_evt, m_evt);
      if (vec_sel !== m_vec)            fail_line("R7", "vec_sel", vec_sel, m_vec);
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) fail_line(req, what, act, exp);
  endtask

  task automatic nclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic settle_check;
    int k;
    k = 0;
    stop_req = 1'b1; wkup_mode = 1'b0;
    rst_n = 1'b1;
    while (!core_rst_n && k < STAB + 10) begin
      @(negedge clk); k++;
      if (k == 5) stop_req = 1'b0;
    end
    check("R1", "settle edges", k, STAB);
    check("R1", "stop masked clk", cpu_clk_en, 1);
    check("R1", "stop masked osc", osc_en, 1);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : scenario
    int k;
    nclk(3);
    // R10 reset values
    check("R10", "cpu_clk_en", cpu_clk_en, 1);
    check("R10", "osc_en", osc_en, 1);
    check("R10", "wkup_evt", wkup_evt, 0);
    check("R10", "vec_sel", vec_sel, 0);
    check("R10", "core_rst_n", core_rst_n, 0);

    settle_check();
    nclk(2);

    // R2, R5, R6, R7: nap on a non-sleep tap, woken by interrupt
    wkup_mode = 1'b1; tap_sel = 2'd2; tmr_cmp = 8'd0; int_en = 1'b1;
    stop_req = 1'b1; nclk(1); stop_req = 1'b0;
    check("R2", "clk off", cpu_clk_en, 0);
    check("R2", "osc on", osc_en, 1);
    nclk(3000);
    check("R5", "still asleep", cpu_clk_en, 0);
    ext_irq = 1'b1; nclk(1); ext_irq = 1'b0;
    check("R6", "wake evt", wkup_evt, 1);
    check("R11", "clk back", cpu_clk_en, 1);
    check("R7", "vector", vec_sel, 1);
    nclk(1);
    check("R11", "evt one cycle", wkup_evt, 0);

    // R4: timer wake, 3 ticks, resume
    tap_sel = 2'd3; tmr_cmp = 8'd2; int_en = 1'b0;
    stop_req = 1'b1; nclk(1); stop_req = 1'b0;
    k = 1;
    while (!wkup_evt && k < 8000) begin nclk(1); k++; end
    check("R4", "nap length in window", (k >= 2 * DIV + 2 && k <= 3 * DIV + 1) ? 1 : 0, 1);
    check("R7", "resume", vec_sel, 0);
    nclk(2);

    // R9: STOP and interrupt together
    int_en = 1'b1;
    stop_req = 1'b1; ext_irq = 1'b1; nclk(1); stop_req = 1'b0; ext_irq = 1'b0;
    check("R9", "clk kept", cpu_clk_en, 1);
    check("R9", "evt pulse", wkup_evt, 1);
    nclk(2);

    // R3, R8: halt ignores interrupt and timer
    wkup_mode = 1'b0; tmr_cmp = 8'd0; int_en = 1'b0;
    stop_req = 1'b1; nclk(1); stop_req = 1'b0;
    check("R3", "clk off", cpu_clk_en, 0);
    check("R3", "osc off", osc_en, 0);
    ext_irq = 1'b1; nclk(1); ext_irq = 1'b0;
    nclk(5000);
    check("R8", "halt held", osc_en, 0);
    check("R8", "no evt", wkup_evt, 0);
    check("R8", "vec unchanged", vec_sel, 1);
    rst_n = 1'b0; nclk(2);
    check("R8", "reset leaves halt", osc_en, 1);
    settle_check();
    nclk(4);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule